// File: doc/BRIEF.md
# Cascaded Synchronous Clock-Enable Divider

This block turns one fast reference clock (nominally 6.144 MHz) into two periodic single-cycle enable pulses, without creating any derived clock net. A fast modulo-5 counter produces a tick once every five reference cycles, which serves as a roughly 1 MHz system timing enable. A slow modulo-8 counter advances only on the cycles where that fast tick is present. Its wrap yields a tick once every forty reference cycles, which is the 16x enable for a 9600 baud serial receiver (153.6 kHz).

Every flip-flop in the block is clocked by the same reference clock edge. The terminal state of the fast counter is decoded and registered. That registered carry is both the fast tick output and the count enable of the slow counter. The terminal decode of the slow stage, gated by the carry, is registered the same way to form the baud tick. This keeps every output a direct flop output, so no decode depth is added in series with the downstream logic. There is no data stream, so the pins are plain control pins with no handshake. Consumers simply qualify their own logic with the ticks.

Top module: `clkdiv_cascade`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, both counters and both tick registers clear. In the cycle after such an edge, `fast_tick` and `baud_tick` are both 0.
- R2: With `rst` low, `fast_tick` is high in the cycle that follows rising edge number 5·k after reset release (k = 1, 2, ...), counting the first edge with `rst` low as edge 1. It is low in every other cycle, so consecutive pulses are exactly FAST_DIV (default 5) cycles apart.
- R3: `fast_tick` is never high in two consecutive cycles.
- R4: With `rst` low, `baud_tick` is high in the cycle that follows edge number 41 + 40·k after reset release (k = 0, 1, ...). It is low in every other cycle, so consecutive pulses are exactly FAST_DIV·SLOW_DIV (default 40) cycles apart.
- R5: `baud_tick` is high only in the cycle immediately after a cycle in which `fast_tick` was high, and the two ticks are never high together.
- R6: Asserting `rst` at any point, including the cycle directly after a `baud_tick`, restarts both pulse sequences, so the R2 and R4 timing is counted again from the new release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; the only clock of the block |
| rst | input | 1 | Synchronous active-high reset |
| fast_tick | output | 1 | One-cycle enable every FAST_DIV cycles (system rate) |
| baud_tick | output | 1 | One-cycle enable every FAST_DIV·SLOW_DIV cycles (16x baud rate) |

## Verification
The bench goes after the phase of the first pulses after a release. A design that fed the slow stage from the undelayed decode instead of the registered carry would place the first baud tick at edge 40 rather than 41, and it would collide with a fast tick. A wrong modulus, such as a counter that runs 0 to 5, stretches the spacing to 6 or 48 cycles, and the per-cycle comparison reports it at the first misplaced pulse. Resets are injected at random moments, including the cycle after a baud tick. A design that failed to clear a counter or a tick register would keep its old phase after the release and miss the restarted schedule.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  // Counter width needed to hold values 0 .. n-1, at least one bit.
  function automatic int cnt_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/cdiv_counter.sv
module cdiv_counter #(
  parameter int MODULUS = 5,
  localparam int W = cdiv_pkg::cnt_width(MODULUS)
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic at_end
);
  localparam logic [W-1:0] LAST = W'(MODULUS - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (adv)
      cnt <= (cnt == LAST) ? '0 : cnt + W'(1);
  end

  // Terminal decode, qualified by the advance so it marks the wrap cycle.
  assign at_end = adv && (cnt == LAST);
endmodule

// File: rtl/cdiv_tick_reg.sv
module cdiv_tick_reg (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= 1'b0;
    else
      q <= d;
  end
endmodule

// File: rtl/clkdiv_cascade.sv
module clkdiv_cascade #(
  parameter int FAST_DIV = 5,
  parameter int SLOW_DIV = 8
) (
  input  logic clk,
  input  logic rst,
  output logic fast_tick,
  output logic baud_tick
);
  logic fast_end;
  logic carry_q;
  logic slow_end;

  cdiv_counter #(.MODULUS(FAST_DIV)) u_fast (
    .clk    (clk),
    .rst    (rst),
    .adv    (1'b1),
    .at_end (fast_end)
  );

  cdiv_tick_reg u_carry (
    .clk (clk),
    .rst (rst),
    .d   (fast_end),
    .q   (carry_q)
  );

  cdiv_counter #(.MODULUS(SLOW_DIV)) u_slow (
    .clk    (clk),
    .rst    (rst),
    .adv    (carry_q),
    .at_end (slow_end)
  );

  cdiv_tick_reg u_baud (
    .clk (clk),
    .rst (rst),
    .d   (slow_end),
    .q   (baud_tick)
  );

  assign fast_tick = carry_q;
endmodule

// File: rtl/clkdiv_cascade_chk.sv
module clkdiv_cascade_chk #(
  parameter int FAST_DIV = 5,
  parameter int SLOW_DIV = 8
) (
  input logic clk,
  input logic rst,
  input logic fast_tick,
  input logic baud_tick
);
  localparam int BAUD_DIV = FAST_DIV * SLOW_DIV;

  int  fgap;
  int  bgap;
  bit  fseen;
  bit  bseen;

  always_ff @(posedge clk) begin
    if (rst) begin
      fgap <= 0; bgap <= 0; fseen <= 1'b0; bseen <= 1'b0;
    end else begin
      fgap <= fast_tick ? 1 : fgap + 1;
      bgap <= baud_tick ? 1 : bgap + 1;
      if (fast_tick) fseen <= 1'b1;
      if (baud_tick) bseen <= 1'b1;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!fast_tick && !baud_tick));

  p_fast_gap_r2: assert property (@(posedge clk) disable iff (rst)
    (fast_tick && fseen) |-> (fgap == FAST_DIV));

  p_fast_single_r3: assert property (@(posedge clk) disable iff (rst)
    fast_tick |=> !fast_tick);

  p_baud_gap_r4: assert property (@(posedge clk) disable iff (rst)
    (baud_tick && bseen) |-> (bgap == BAUD_DIV));

  p_baud_after_fast_r5: assert property (@(posedge clk) disable iff (rst)
    baud_tick |-> ($past(fast_tick) && !fast_tick));
endmodule

bind clkdiv_cascade clkdiv_cascade_chk #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .fast_tick (fast_tick),
  .baud_tick (baud_tick)
);

// File: tb/sim_clkdiv_cascade.sv
`timescale 1ns/1ps
module sim_clkdiv_cascade;
  localparam real CLK_PERIOD = 162.76;
  localparam int  FDIV = 5;
  localparam int  BDIV = 40;
  localparam int  MAX_CYC = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fast_tick, baud_tick;

  int n_cmp = 0;
  int n_bad = 0;
  int edges = 0;       // rising edges since reset release
  int cyc = 0;
  bit done = 1'b0;

  clkdiv_cascade u0 (
    .clk       (clk),
    .rst       (rst),
    .fast_tick (fast_tick),
    .baud_tick (baud_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit exp_fast(input int e);
    return (e >= FDIV) && (e % FDIV == 0);
  endfunction

  function automatic bit exp_baud(input int e);
    return (e >= BDIV + 1) && ((e - (BDIV + 1)) % BDIV == 0);
  endfunction

  // Reference edge count, updated at the same edge the design samples rst.
  bit rst_at_edge = 1'b1;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) edges <= 0;
    else     edges <= edges + 1;
    rst_at_edge <= rst;
  end

  task automatic check(input string req, input bit act, input bit expv, input string nm);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", req, nm, cyc, act, expv);
    end
  endtask

  // Per-cycle comparison, sampled mid-cycle.
  always @(negedge clk) begin
    if (!done) begin
      if (rst_at_edge) begin
        check("R1", fast_tick, 1'b0, "fast_tick after reset edge");
        check("R1", baud_tick, 1'b0, "baud_tick after reset edge");
      end else begin
        check("R2", fast_tick, exp_fast(edges), "fast_tick");
        check("R4", baud_tick, exp_baud(edges), "baud_tick");
        check("R5", fast_tick && baud_tick, 1'b0, "ticks coincide");
      end
    end
  end

  // R3 tracked separately: no back-to-back fast ticks.
  bit prev_fast = 1'b0;
  always @(negedge clk) begin
    if (!done && !rst_at_edge && prev_fast && fast_tick) begin
      n_bad++;
      $display("FAIL R3 fast_tick high two cycles: actual 1 expected 0");
    end
    prev_fast <= fast_tick;
  end

  task automatic wait_cycles(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed_1234);
    // Directed: initial reset, long run through several baud periods.
    rst = 1'b1;
    wait_cycles(3);
    rst = 1'b0;
    wait_cycles(200);
    // Directed R6: reset in the cycle right after a baud tick.
    while (!baud_tick) @(negedge clk);
    rst = 1'b1;
    wait_cycles(1);
    rst = 1'b0;
    wait_cycles(130);
    // Directed R6: reset mid fast count.
    wait_cycles(2);
    rst = 1'b1;
    wait_cycles(2);
    rst = 1'b0;
    wait_cycles(100);
    // Random reset pulses at random moments (R6).
    for (int i = 0; i < 60; i++) begin
      wait_cycles(1 + ($urandom % 300));
      rst = 1'b1;
      wait_cycles(1 + ($urandom % 3));
      rst = 1'b0;
    end
    wait_cycles(500);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * MAX_CYC);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule